// File: doc/BRIEF.md
# Supply Controller Register Target on a Two-Wire Serial Bus

This block is a two-wire serial bus (I2C) target that holds the control and status registers of a low-noise-block supply controller with tone signalling. It watches the clock and data lines through a synchronizer running on the system clock. It recognises START, STOP and repeated START conditions. It answers one 7-bit address, whose lowest bit comes live from a strap pin.

A single-byte write sets one of two control registers, and those registers drive the rest of the chip directly. A single-byte read returns a control register, or a snapshot of the live fault and health flags. When the status byte has been shifted out and the master's acknowledge bit has been sampled, the block emits a one-cycle `status_read` strobe. Sticky fault logic elsewhere uses this strobe to release its latched bits. The interface keeps working whatever the control registers say, including while the supply output is disabled.

Top module: `i2c_supply_regs`

## Requirements
- R1: The target answers only the 7-bit address 0b110000x, where x equals `addr_strap` (0x60 when low, 0x61 when high). Any other address, including the all-zero general call, is not acknowledged, leaves every register as it was, and causes no SDA drive until the next START.
- R2: For each byte a matched master sends (address, register pointer, data), the target pulls SDA low for the whole high phase of the ninth clock and releases it after that clock falls.
- R3: A write (address with R/W=0, pointer byte, data byte) updates the addressed register once the eighth data bit has been clocked in. The control outputs change at no other time.
- R4: Register 0x00 stores all 8 bits, is read back unchanged, and resets to 0x08.
- R5: Register 0x01 stores bits 4..0, reads bits 7..5 as zero, and resets to 0x09.
- R6: SDA is never driven while the bus is idle, after reset, or after a STOP.
- R7: A read (pointer write, repeated START, address with R/W=1) returns the addressed register MSB first. Each bit is placed on SDA while SCL is low.
- R8: Register 0x02 returns `stat_in` at the moment the read starts, with bits 7 and 4 forced to zero. Writes to 0x02 and to any pointer above 0x02 are acknowledged and have no effect.
- R9: `status_read` pulses high for exactly one cycle, and only after the ninth clock of a read of register 0x02 has risen. Reads of other registers give no pulse.
- R10: Reads of any pointer above 0x02 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| addr_strap | input | 1 | Selects the lowest address bit |
| stat_in | input | 8 | Live status flags (bit6 hot, bit5 regulator on, bit3 thermal trip, bit2 overcurrent, bit1 load present, bit0 output in range) |
| ctrl0 | output | 8 | Control register 0x00 |
| ctrl1 | output | 8 | Control register 0x01 |
| status_read | output | 1 | One-cycle strobe after a status byte has been read |

## Verification
A wrong bit counter or a wrong protocol state shows at SDA within one byte. The acknowledge either goes missing, lands on the wrong clock or appears for a foreign address, and a read returns shifted or stale data. A wrong register write is visible on `ctrl0`/`ctrl1` a few cycles after the data byte completes, because the bench compares both on every clock against its own model. A misplaced status strobe shows up on the first clock where it fires outside the master's acknowledge slot of a status read.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    localparam logic [5:0] TGT_ADDR_HI = 6'b110000;

    localparam logic [BYTE_W-1:0] PTR_CTRL0 = 8'h00;
    localparam logic [BYTE_W-1:0] PTR_CTRL1 = 8'h01;
    localparam logic [BYTE_W-1:0] PTR_STAT  = 8'h02;

    localparam logic [BYTE_W-1:0] CTRL0_RST  = 8'h08;
    localparam logic [BYTE_W-1:0] CTRL1_RST  = 8'h09;
    localparam logic [BYTE_W-1:0] CTRL1_MASK = 8'h1F;
    localparam logic [BYTE_W-1:0] STAT_MASK  = 8'h6F;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_PTR, ST_PTR_ACK,
        ST_WDATA, ST_WDATA_ACK, ST_TX, ST_TX_ACK, ST_SKIP
    } bus_st_e;

    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] ptr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic logic addr_hit(input logic [6:0] a, input logic lsb);
        return a == {TGT_ADDR_HI, lsb};
    endfunction

endpackage

// File: rtl/i2cr_line_sync.sv
module i2cr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q, scl_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cr_bus_fsm.sv
module i2cr_bus_fsm
    import i2cr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              addr_lsb,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] ptr,
    output wr_req_t           wr_req,
    output logic              sda_oe,
    output logic              status_read,
    output logic              bus_idle
);
    bus_st_e           st;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh, tx;
    logic              rw;

    assign bus_idle = (st == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            cnt         <= '0;
            sh          <= '0;
            tx          <= '0;
            rw          <= 1'b0;
            ptr         <= '0;
            wr_req      <= '0;
            sda_oe      <= 1'b0;
            status_read <= 1'b0;
        end else begin
            wr_req.vld  <= 1'b0;
            status_read <= 1'b0;
            if (start_det) begin
                st     <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (st)
                    ST_ADDR, ST_PTR, ST_WDATA: begin
                        if (scl_rise) begin
                            sh  <= {sh[BYTE_W-2:0], sda_s};
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
                            if (st == ST_ADDR) begin
                                if (addr_hit(sh[7:1], addr_lsb)) begin
                                    sda_oe <= 1'b1;
                                    rw     <= sh[0];
                                    st     <= ST_ADDR_ACK;
                                end else begin
                                    st <= ST_SKIP;
                                end
                            end else if (st == ST_PTR) begin
                                ptr    <= sh;
                                sda_oe <= 1'b1;
                                st     <= ST_PTR_ACK;
                            end else begin
                                wr_req <= '{vld: 1'b1, ptr: ptr, data: sh};
                                sda_oe <= 1'b1;
                                st     <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                st     <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= ST_PTR;
                            end
                        end
                    end
                    ST_PTR_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            st     <= ST_WDATA;
                        end
                    end
                    ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            st     <= ST_SKIP;
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (cnt == CNT_W'(BYTE_W - 1)) begin
                                sda_oe <= 1'b0;
                                st     <= ST_TX_ACK;
                            end else begin
                                cnt    <= cnt + 1'b1;
                                tx     <= {tx[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx[BYTE_W-2];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            status_read <= (ptr == PTR_STAT);
                            st          <= ST_SKIP;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2cr_regfile.sv
module i2cr_regfile
    import i2cr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr_req,
    input  logic [BYTE_W-1:0] rd_ptr,
    input  logic [BYTE_W-1:0] stat_in,
    output logic [BYTE_W-1:0] ctrl0,
    output logic [BYTE_W-1:0] ctrl1,
    output logic [BYTE_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl0 <= CTRL0_RST;
            ctrl1 <= CTRL1_RST;
        end else if (wr_req.vld) begin
            if (wr_req.ptr == PTR_CTRL0) ctrl0 <= wr_req.data;
            if (wr_req.ptr == PTR_CTRL1) ctrl1 <= wr_req.data & CTRL1_MASK;
        end
    end

    always_comb begin
        unique case (rd_ptr)
            PTR_CTRL0: rd_data = ctrl0;
            PTR_CTRL1: rd_data = ctrl1;
            PTR_STAT:  rd_data = stat_in & STAT_MASK;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/i2c_supply_regs.sv
module i2c_supply_regs
    import i2cr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic              addr_strap,
    input  logic [BYTE_W-1:0] stat_in,
    output logic [BYTE_W-1:0] ctrl0,
    output logic [BYTE_W-1:0] ctrl1,
    output logic              status_read
);
    logic sda_s, scl_rise, scl_fall, start_det, stop_det, bus_idle, wr_stb;
    logic [BYTE_W-1:0] ptr, rd_data;
    wr_req_t wr_req;

    assign wr_stb = wr_req.vld;

    i2cr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cr_bus_fsm u_fsm (
        .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .addr_lsb(addr_strap), .rd_data(rd_data), .ptr(ptr),
        .wr_req(wr_req), .sda_oe(sda_oe), .status_read(status_read),
        .bus_idle(bus_idle)
    );

    i2cr_regfile u_regs (
        .clk(clk), .rst(rst), .wr_req(wr_req), .rd_ptr(ptr),
        .stat_in(stat_in), .ctrl0(ctrl0), .ctrl1(ctrl1), .rd_data(rd_data)
    );
endmodule

// File: rtl/i2cr_chk.sv
module i2cr_chk (
    input logic       clk,
    input logic       rst,
    input logic       sda_oe,
    input logic       status_read,
    input logic [7:0] ctrl0,
    input logic [7:0] ctrl1,
    input logic       wr_stb,
    input logic       scl_rise,
    input logic       scl_fall,
    input logic       start_det,
    input logic       stop_det,
    input logic       bus_idle
);
    // R9: strobe lasts a single cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        status_read |=> !status_read);

    // R9: strobe follows a sampled rising clock edge
    a_r9_after_rise: assert property (@(posedge clk) disable iff (rst)
        status_read |-> $past(scl_rise));

    // R3: control outputs move only after a completed write byte
    a_r3_ctrl0_on_write: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl0) |-> $past(wr_stb));
    a_r3_ctrl1_on_write: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl1) |-> $past(wr_stb));

    // R6: no drive while idle
    a_r6_idle_no_drive: assert property (@(posedge clk) disable iff (rst)
        bus_idle |-> !sda_oe);

    // R2, R7: SDA drive changes only while SCL is low or on bus conditions
    a_r7_drive_on_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> $past(scl_fall | start_det | stop_det));
endmodule

bind i2c_supply_regs i2cr_chk u_chk (
    .clk(clk), .rst(rst), .sda_oe(sda_oe), .status_read(status_read),
    .ctrl0(ctrl0), .ctrl1(ctrl1), .wr_stb(wr_stb), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .bus_idle(bus_idle)
);

// File: tb/sim_i2c_supply_regs.sv
`timescale 1ns/1ps
module sim_i2c_supply_regs;
    localparam int Q = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic addr_strap = 1'b0;
    logic [7:0] stat_in = 8'h00;
    logic sda_oe, status_read;
    logic [7:0] ctrl0, ctrl1;
    wire  sda_line = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    i2c_supply_regs u0 (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
        .sda_oe(sda_oe), .addr_strap(addr_strap), .stat_in(stat_in),
        .ctrl0(ctrl0), .ctrl1(ctrl1), .status_read(status_read)
    );

    int total = 0, bad = 0, sr_cnt = 0;
    logic [7:0] exp0 = 8'h08, exp1 = 8'h09;
    bit mask_ctrl = 1'b1, allow_sr = 1'b0, quiet = 1'b1, done = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock reference comparison
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            if (status_read) sr_cnt++;
            if (!mask_ctrl) begin
                chk(ctrl0 == exp0, "R4 ctrl0 model", ctrl0, exp0);
                chk(ctrl1 == exp1, "R5 ctrl1 model", ctrl1, exp1);
            end
            if (status_read && !allow_sr) chk(1'b0, "R9 stray strobe", 1, 0);
            if (quiet && sda_oe) chk(1'b0, "R6 drive while idle", 1, 0);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart();
        quiet = 1'b0;
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bstop();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
        tick(Q);
        quiet = 1'b1;
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; tick(Q); scl_m = 1'b1; tick(Q); tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack);
        logic a1, a2;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(1); a1 = sda_line;
        tick(2*Q-2); a2 = sda_line; tick(1); scl_m = 1'b0; tick(Q);
        ack = (a1 == 1'b0) && (a2 == 1'b0);
    endtask

    task automatic recv_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
            v[i] = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
        end
    endtask

    function automatic bit hit(input logic [6:0] a);
        return a == {6'b110000, addr_strap};
    endfunction

    task automatic wr_reg(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d,
                          output bit acked);
        bit k0, k1, k2;
        k1 = 0; k2 = 0;
        bstart();
        send_byte({a, 1'b0}, k0);
        if (k0) begin
            send_byte(p, k1);
            mask_ctrl = 1'b1;
            send_byte(d, k2);
            if (hit(a)) begin
                if (p == 8'h00) exp0 = d;
                if (p == 8'h01) exp1 = d & 8'h1F;
            end
            mask_ctrl = 1'b0;
        end
        bstop();
        acked = k0 & k1 & k2;
    endtask

    task automatic rd_reg(input logic [6:0] a, input logic [7:0] p, output logic [7:0] d,
                          output bit acked);
        bit k0, k1, k2;
        d = 8'hXX; k1 = 0; k2 = 0;
        bstart();
        send_byte({a, 1'b0}, k0);
        if (k0) begin
            send_byte(p, k1);
            bstart();
            send_byte({a, 1'b1}, k2);
            if (k2) begin
                recv_byte(d);
                allow_sr = (p == 8'h02);
                send_bit(1'b1);
            end
        end
        bstop();
        allow_sr = 1'b0;
        acked = k0 & k1 & k2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit ok;
        logic [7:0] d;
        int s0;
        tick(10);
        rst = 1'b0;
        tick(2);
        chk(ctrl0 == 8'h08, "R4 reset ctrl0", ctrl0, 8'h08);
        chk(ctrl1 == 8'h09, "R5 reset ctrl1", ctrl1, 8'h09);
        chk(sda_oe == 1'b0, "R6 reset no drive", sda_oe, 0);
        mask_ctrl = 1'b0;

        // R2 R3 R4: write register 0
        wr_reg(7'h60, 8'h00, 8'hA5, ok);
        chk(ok, "R2 write acks", ok, 1);
        chk(ctrl0 == 8'hA5, "R3 ctrl0 after write", ctrl0, 8'hA5);
        // R5: upper bits of register 1 not stored
        wr_reg(7'h60, 8'h01, 8'hFF, ok);
        chk(ctrl1 == 8'h1F, "R5 ctrl1 masked", ctrl1, 8'h1F);

        // R7: reads
        rd_reg(7'h60, 8'h00, d, ok);
        chk(ok && d == 8'hA5, "R7 read ctrl0", d, 8'hA5);
        rd_reg(7'h60, 8'h01, d, ok);
        chk(ok && d == 8'h1F, "R5 read ctrl1", d, 8'h1F);

        // R8 R9: status read with strobe
        stat_in = 8'hFF; s0 = sr_cnt;
        rd_reg(7'h60, 8'h02, d, ok);
        chk(d == 8'h6F, "R8 status masked", d, 8'h6F);
        chk(sr_cnt == s0 + 1, "R9 one strobe", sr_cnt - s0, 1);
        stat_in = 8'h2A; s0 = sr_cnt;
        rd_reg(7'h60, 8'h02, d, ok);
        chk(d == 8'h2A, "R8 status live", d, 8'h2A);
        chk(sr_cnt == s0 + 1, "R9 second strobe", sr_cnt - s0, 1);
        stat_in = 8'h10;
        rd_reg(7'h60, 8'h02, d, ok);
        chk(d == 8'h00, "R8 bit4 forced zero", d, 8'h00);
        s0 = sr_cnt;
        rd_reg(7'h60, 8'h00, d, ok);
        chk(sr_cnt == s0, "R9 no strobe for ctrl read", sr_cnt - s0, 0);

        // R1: foreign addresses
        wr_reg(7'h61, 8'h00, 8'h3C, ok);
        chk(!ok, "R1 0x61 nack with strap low", ok, 0);
        chk(ctrl0 == 8'hA5, "R1 ctrl0 untouched", ctrl0, 8'hA5);
        wr_reg(7'h00, 8'h00, 8'h3C, ok);
        chk(!ok, "R1 general call nack", ok, 0);
        wr_reg(7'h78, 8'h00, 8'h3C, ok);
        chk(!ok, "R1 ten-bit prefix nack", ok, 0);

        // R1: strap high, output disabled still operational
        addr_strap = 1'b1; tick(4);
        wr_reg(7'h61, 8'h00, 8'h00, ok);
        chk(ok && ctrl0 == 8'h00, "R1 0x61 with strap high", ctrl0, 8'h00);
        wr_reg(7'h60, 8'h01, 8'h00, ok);
        chk(!ok && ctrl1 == 8'h1F, "R1 0x60 nack with strap high", ctrl1, 8'h1F);
        wr_reg(7'h61, 8'h00, 8'h5A, ok);
        chk(ctrl0 == 8'h5A, "R3 write while disabled", ctrl0, 8'h5A);

        // R8 R10: ignored writes and unmapped reads
        wr_reg(7'h61, 8'h02, 8'h55, ok);
        chk(ok, "R8 status write acked", ok, 1);
        wr_reg(7'h61, 8'h07, 8'hFF, ok);
        chk(ok && ctrl0 == 8'h5A && ctrl1 == 8'h1F, "R8 unmapped write ignored", ctrl0, 8'h5A);
        stat_in = 8'h03;
        rd_reg(7'h61, 8'h02, d, ok);
        chk(d == 8'h03, "R8 status after write attempt", d, 8'h03);
        rd_reg(7'h61, 8'h07, d, ok);
        chk(ok && d == 8'h00, "R10 unmapped read 0x07", d, 8'h00);
        rd_reg(7'h61, 8'h03, d, ok);
        chk(ok && d == 8'h00, "R10 unmapped read 0x03", d, 8'h00);
        chk(sda_oe == 1'b0, "R6 released after stop", sda_oe, 0);

        tick(20);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule